// File: doc/BRIEF.md
# Registered Integer Execute Stage

This block is the integer execute stage of a 32-bit load-store core. Each cycle it takes two register operands, a four-bit operation code, a 16-bit immediate field and a flag that selects the immediate in place of the second operand. It computes one result and registers it, so the result appears one clock after the operands are presented. The stage covers addition and subtraction, the four bitwise logic functions, signed and unsigned less-than compares, placing a constant in the upper half-word, and three kinds of shift.

Addition and subtraction come in two forms. The trapping form raises a trap flag on signed overflow and drops the register-write enable for that cycle, so the core can discard the result. The wrapping form never traps. When the immediate is selected, it is zero-extended for the bitwise operations and sign-extended for the arithmetic and compare operations. A shift takes its amount from a five-bit field of the immediate or from the low bits of the second operand. Register-file access, multiply and divide, memory access and exception dispatch are outside the stage.

Top module: `alu_exec`

## Requirements
- R1: Operation codes are 0 ADD, 1 ADDU, 2 SUB, 3 SUBU, 4 AND, 5 OR, 6 XOR, 7 NOR, 8 SLT, 9 SLTU, 10 LUI, 11 SLL, 12 SRL, 13 SRA. Codes 14 and 15 yield a zero result and no trap. Each result is the full 32-bit value, registered one clock after its inputs.
- R2: ADD, ADDU, SUB and SUBU return the 32-bit sum or difference modulo 2^32. The second operand is `opb_i`, or the extended immediate when `imm_sel_i` is 1.
- R3: `trap_o` is 1 only for ADD or SUB with two's-complement overflow. ADDU, SUBU, the logic ops, the compares, LUI and the shifts never set it.
- R4: `wr_en_o` is 0 in a cycle whose result traps and 1 for every other result.
- R5: With `imm_sel_i`=1, AND, OR and XOR use the immediate zero-extended to 32 bits.
- R6: With `imm_sel_i`=1, ADD, ADDU, SUB, SUBU, SLT and SLTU use the immediate sign-extended from bit 15.
- R7: SLT returns 1 when A < B as two's-complement numbers and 0 otherwise. SLTU returns 1 when A < B as unsigned numbers and 0 otherwise.
- R8: LUI returns the immediate in bits 31:16 and zeros in bits 15:0, whatever `imm_sel_i` holds.
- R9: SLL and SRL shift `opa_i` and fill with zeros. SRA fills with bit 31 of `opa_i`.
- R10: The shift amount is `imm_i[10:6]` when `imm_sel_i`=1 and `opb_i[4:0]` otherwise. Bits 31:5 of `opb_i` have no effect on a shift.
- R11: NOR returns the inverse of the bitwise OR of the two operands.
- R12: While `rst_ni` is low, `result_o`, `trap_o` and `wr_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand or shift-amount register |
| imm_i | input | 16 | Immediate field |
| imm_sel_i | input | 1 | Use the extended immediate as the second operand and take the shift amount from the immediate |
| result_o | output | 32 | Registered result |
| trap_o | output | 1 | Registered signed-overflow trap |
| wr_en_o | output | 1 | Registered destination write enable |

## Verification
A result and its trap can land in the same output cycle: an overflowing ADD or SUB must show the wrapped sum, `trap_o` high and `wr_en_o` low all at once. The bench presents the same operand pairs (0x7FFFFFFF plus 1, 0x80000000 minus 1, and an immediate of 0xFFFF extended by sign) to both the trapping and the wrapping forms on back-to-back cycles. The scoreboard then compares all three outputs of each cycle together. A trap that is late, or that leaks into the next wrapping operation, shows up as a mismatch on that neighbouring cycle.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SLT  = 4'd8,
        OP_SLTU = 4'd9,
        OP_LUI  = 4'd10,
        OP_SLL  = 4'd11,
        OP_SRL  = 4'd12,
        OP_SRA  = 4'd13
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2
    } shift_kind_e;
endpackage

// File: rtl/alu_opnd.sv
module alu_opnd #(
    parameter int XLEN = 32,
    parameter int IMMW = 16,
    parameter int SHW  = $clog2(XLEN),
    parameter int SHLO = 6
) (
    input  logic [XLEN-1:0] opb_i,
    input  logic [IMMW-1:0] imm_i,
    input  logic            imm_sel_i,
    input  logic            zext_i,
    output logic [XLEN-1:0] b_eff_o,
    output logic [SHW-1:0]  shamt_o
);
    localparam int PADW = XLEN - IMMW;

    logic [XLEN-1:0] imm_ext;

    always_comb begin
        if (zext_i) imm_ext = {{PADW{1'b0}}, imm_i};
        else        imm_ext = {{PADW{imm_i[IMMW-1]}}, imm_i};
        b_eff_o = imm_sel_i ? imm_ext : opb_i;
        shamt_o = imm_sel_i ? imm_i[SHLO+SHW-1:SHLO] : opb_i[SHW-1:0];
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sub_i,
    output logic [XLEN-1:0] sum_o,
    output logic            ovf_o,
    output logic            lt_s_o,
    output logic            lt_u_o
);
    localparam int MSB = XLEN - 1;

    logic [XLEN:0]   wide;
    logic [XLEN-1:0] b_inv;

    always_comb begin
        b_inv = sub_i ? ~b_i : b_i;
        wide  = {1'b0, a_i} + {1'b0, b_inv} + {{XLEN{1'b0}}, sub_i};
        sum_o = wide[MSB:0];
        // overflow: effective operand signs agree, result sign differs
        ovf_o  = (a_i[MSB] == b_inv[MSB]) && (sum_o[MSB] != a_i[MSB]);
        // unsigned borrow: no carry out of a - b
        lt_u_o = ~wide[XLEN];
        lt_s_o = (a_i[MSB] != b_i[MSB]) ? a_i[MSB] : sum_o[MSB];
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]          data_i,
    input  logic [SHW-1:0]           amt_i,
    input  alu_pkg::shift_kind_e     kind_i,
    output logic [XLEN-1:0]          data_o
);
    import alu_pkg::*;

    logic            fill;
    logic [XLEN-1:0] stg [SHW+1];

    assign fill   = (kind_i == SH_ARITH) & data_i[XLEN-1];
    assign stg[0] = data_i;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int DIST = 1 << i;
        logic [XLEN-1:0] moved;
        always_comb begin
            if (kind_i == SH_LEFT)
                moved = {stg[i][XLEN-1-DIST:0], {DIST{1'b0}}};
            else
                moved = {{DIST{fill}}, stg[i][XLEN-1:DIST]};
        end
        assign stg[i+1] = amt_i[i] ? moved : stg[i];
    end

    assign data_o = stg[SHW];
endmodule

// File: rtl/alu_exec.sv
module alu_exec #(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [3:0]      op_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic [IMMW-1:0] imm_i,
    input  logic            imm_sel_i,
    output logic [XLEN-1:0] result_o,
    output logic            trap_o,
    output logic            wr_en_o
);
    import alu_pkg::*;

    localparam int SHW  = $clog2(XLEN);
    localparam int LOWW = XLEN - IMMW;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            trap;
        logic            wr_en;
    } exec_st_t;

    exec_st_t    stage_d, stage_q;
    alu_op_e     op;
    logic        is_logic, is_sub;
    logic [XLEN-1:0] b_eff, sum, shifted;
    logic [SHW-1:0]  shamt;
    logic        ovf, lt_s, lt_u;
    shift_kind_e sh_kind;

    assign op       = alu_op_e'(op_i);
    assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
    assign is_sub   = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);

    always_comb begin
        case (op)
            OP_SRL:  sh_kind = SH_RIGHT;
            OP_SRA:  sh_kind = SH_ARITH;
            default: sh_kind = SH_LEFT;
        endcase
    end

    alu_opnd #(.XLEN(XLEN), .IMMW(IMMW), .SHW(SHW)) u_opnd (
        .opb_i     (opb_i),
        .imm_i     (imm_i),
        .imm_sel_i (imm_sel_i),
        .zext_i    (is_logic),
        .b_eff_o   (b_eff),
        .shamt_o   (shamt)
    );

    alu_addsub #(.XLEN(XLEN)) u_addsub (
        .a_i    (opa_i),
        .b_i    (b_eff),
        .sub_i  (is_sub),
        .sum_o  (sum),
        .ovf_o  (ovf),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u)
    );

    alu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
        .data_i (opa_i),
        .amt_i  (shamt),
        .kind_i (sh_kind),
        .data_o (shifted)
    );

    always_comb begin
        stage_d = '0;
        case (op)
            OP_ADD, OP_SUB: begin
                stage_d.result = sum;
                stage_d.trap   = ovf;
            end
            OP_ADDU, OP_SUBU: stage_d.result = sum;
            OP_AND:  stage_d.result = opa_i & b_eff;
            OP_OR:   stage_d.result = opa_i | b_eff;
            OP_XOR:  stage_d.result = opa_i ^ b_eff;
            OP_NOR:  stage_d.result = ~(opa_i | b_eff);
            OP_SLT:  stage_d.result = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU: stage_d.result = {{(XLEN-1){1'b0}}, lt_u};
            OP_LUI:  stage_d.result = {imm_i, {LOWW{1'b0}}};
            OP_SLL, OP_SRL, OP_SRA: stage_d.result = shifted;
            default: stage_d.result = '0;
        endcase
        stage_d.wr_en = ~stage_d.trap;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= stage_d;
    end

    assign result_o = stage_q.result;
    assign trap_o   = stage_q.trap;
    assign wr_en_o  = stage_q.wr_en;

    // R3: a trap is only ever reported for the trapping add or subtract
    a_r3_trap_signed_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> ($past(op_i) == OP_ADD || $past(op_i) == OP_SUB));

    // R8: upper-constant load
    a_r8_lui_layout: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_LUI) |=> (result_o == {$past(imm_i), {LOWW{1'b0}}}));

    // R7: compares produce a single bit
    a_r7_compare_bool: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_SLT || op_i == OP_SLTU) |=> (result_o[XLEN-1:1] == '0 && !trap_o));

    // R11: inverted OR with register operands
    a_r11_nor_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_NOR && !imm_sel_i) |=> (result_o == ~($past(opa_i) | $past(opb_i))));

    // R4: non-arithmetic operations always leave the write enabled
    a_r4_logic_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i >= OP_AND) |=> wr_en_o);
endmodule

// File: tb/alu_exec_bench.sv
module alu_exec_bench;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [15:0] imm_i = '0;
    logic        imm_sel_i = 1'b0;
    logic [31:0] result_o;
    logic        trap_o;
    logic        wr_en_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] res;
        logic        trap;
        logic        wen;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk_i = ~clk_i;

    alu_exec u_alu_exec (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .op_i      (op_i),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .imm_i     (imm_i),
        .imm_sel_i (imm_sel_i),
        .result_o  (result_o),
        .trap_o    (trap_o),
        .wr_en_o   (wr_en_o)
    );

    function automatic exp_t predict(string tag, int op, logic [31:0] a, logic [31:0] b,
                                     logic [15:0] im, logic isel);
        exp_t e;
        logic [31:0] sx, zx, bl, ba;
        logic [4:0]  sh;
        sx = {{16{im[15]}}, im};
        zx = {16'h0, im};
        bl = isel ? zx : b;
        ba = isel ? sx : b;
        sh = isel ? im[10:6] : b[4:0];
        e.tag = tag; e.trap = 1'b0; e.res = '0;
        case (op)
            0: begin e.res = a + ba; e.trap = (a[31] == ba[31]) && (e.res[31] != a[31]); end
            1: e.res = a + ba;
            2: begin e.res = a - ba; e.trap = (a[31] != ba[31]) && (e.res[31] != a[31]); end
            3: e.res = a - ba;
            4: e.res = a & bl;
            5: e.res = a | bl;
            6: e.res = a ^ bl;
            7: e.res = ~(a | bl);
            8: e.res = ($signed(a) < $signed(ba)) ? 32'd1 : 32'd0;
            9: e.res = (a < ba) ? 32'd1 : 32'd0;
            10: e.res = {im, 16'h0};
            11: e.res = a << sh;
            12: e.res = a >> sh;
            13: e.res = $unsigned($signed(a) >>> sh);
            default: e.res = '0;
        endcase
        e.wen = ~e.trap;
        return e;
    endfunction

    task automatic apply(string tag, int op, logic [31:0] a, logic [31:0] b,
                         logic [15:0] im, logic isel);
        @(negedge clk_i);
        op_i = op[3:0]; opa_i = a; opb_i = b; imm_i = im; imm_sel_i = isel;
        exp_q.push_back(predict(tag, op, a, b, im, isel));
    endtask

    always @(posedge clk_i) begin
        #2;
        if (rst_ni && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (result_o !== e.res || trap_o !== e.trap || wr_en_o !== e.wen) begin
                n_bad++;
                $display("FAIL %s: got res=%h trap=%b wen=%b expected res=%h trap=%b wen=%b",
                         e.tag, result_o, trap_o, wr_en_o, e.res, e.trap, e.wen);
            end
        end
    end

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk_i);
        n_bad++;
        $display("FAIL watchdog: got running expected finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk_i);
        // R12: outputs cleared during reset
        n_cmp++;
        if (result_o !== 32'h0 || trap_o !== 1'b0 || wr_en_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R12: got res=%h trap=%b wen=%b expected res=0 trap=0 wen=0",
                     result_o, trap_o, wr_en_o);
        end
        rst_ni = 1'b1;

        // R2, R3, R4: trap and write gating next to wrapping forms
        apply("R2", 1, 32'd100, 32'd23, 16'h0, 1'b0);
        apply("R3", 0, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0);
        apply("R4", 1, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0);
        apply("R3", 2, 32'h8000_0000, 32'd1, 16'h0, 1'b0);
        apply("R4", 3, 32'h8000_0000, 32'd1, 16'h0, 1'b0);
        apply("R3", 0, 32'h8000_0000, 32'h8000_0000, 16'h0, 1'b0);
        apply("R2", 2, 32'd5, 32'd9, 16'h0, 1'b0);
        apply("R3", 2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 1'b0);
        // R6: sign-extended immediates on arithmetic and compares
        apply("R6", 0, 32'h8000_0000, 32'h0, 16'hFFFF, 1'b1);
        apply("R6", 1, 32'd10, 32'hDEAD, 16'hFFFF, 1'b1);
        apply("R6", 3, 32'd10, 32'h0, 16'h8000, 1'b1);
        apply("R6", 8, 32'd0, 32'h0, 16'hFFFF, 1'b1);
        apply("R6", 9, 32'd5, 32'h0, 16'hFFFF, 1'b1);
        // R5: zero-extended immediates on logic ops
        apply("R5", 4, 32'hFFFF_FFFF, 32'h0, 16'h8F0F, 1'b1);
        apply("R5", 5, 32'h1234_0000, 32'h0, 16'hF000, 1'b1);
        apply("R5", 6, 32'hFFFF_FFFF, 32'h0, 16'h8001, 1'b1);
        // R11 and register-form logic
        apply("R11", 7, 32'hF0F0_0000, 32'h0000_0F0F, 16'h0, 1'b0);
        apply("R11", 7, 32'h0, 32'h0, 16'h8000, 1'b1);
        apply("R1", 4, 32'hFF00_FF00, 32'h0FF0_0FF0, 16'h0, 1'b0);
        // R7: signed vs unsigned compares
        apply("R7", 8, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0);
        apply("R7", 9, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0);
        apply("R7", 8, 32'd2, 32'd1, 16'h0, 1'b0);
        apply("R7", 9, 32'd1, 32'd2, 16'h0, 1'b0);
        apply("R7", 8, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0);
        // R8: upper constant, flag ignored
        apply("R8", 10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hABCD, 1'b0);
        apply("R8", 10, 32'h0, 32'h0, 16'h8001, 1'b1);
        // R9, R10: shifts
        apply("R9", 11, 32'h8000_0001, 32'd4, 16'h0, 1'b0);
        apply("R9", 12, 32'h8000_0000, 32'd31, 16'h0, 1'b0);
        apply("R9", 13, 32'h8000_0000, 32'd31, 16'h0, 1'b0);
        apply("R9", 13, 32'h4000_0000, 32'd8, 16'h0, 1'b0);
        apply("R10", 12, 32'hF000_0000, 32'hFFFF_FFE4, 16'h0, 1'b0);
        apply("R10", 13, 32'h8000_0000, 32'h0, 16'h0140, 1'b1);
        apply("R10", 11, 32'h0000_0003, 32'h0, 16'h07C0, 1'b1);
        apply("R10", 11, 32'h1234_5678, 32'h0000_0020, 16'h0, 1'b0);
        // R1: unused codes
        apply("R1", 14, 32'h7FFF_FFFF, 32'd1, 16'hFFFF, 1'b0);
        apply("R1", 15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1'b1);
        apply("R3", 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'h0, 1'b0);

        @(negedge clk_i);
        op_i = 4'd1;
        while (exp_q.size() > 0) @(negedge clk_i);
        @(negedge clk_i);
        finish_up();
    end
endmodule